// File: doc/BRIEF.md
# Counter Interrupt Flag Aggregator

This block runs a 16-bit up-counter and collects eight event flags into one registered interrupt request. Two of the flags come from the counter itself. One is set when the counter wraps. The other is set when a carry leaves a low slice of the counter, and software picks the width of that slice: 8, 9, 10 or 11 bits. The remaining six flags are set by external per-channel event inputs.

Every flag stays set until software clears it by writing a one to its bit. A flag is set whether or not it is enabled. The request goes high only when a flag is pending on an enabled source and both global gates are open. A small write port holds the control bits, the per-source enable mask and the clear strobe. The flag vector and the counter value are available as outputs, so the surrounding logic can see which source is pending.

Top module: `cntr_irq_agg`

## Requirements
- R1: The counter adds one on each clock where `cnt_en` is 1 and the run bit (CTRL bit 0) is 1. It wraps from 0xFFFF to 0. In every other cycle it holds its value.
- R2: Flag bit 0 is set when the counter steps from 0xFFFF to 0.
- R3: Flag bit 1 is set when the counter steps while its low N bits are all ones, where N = 8 + CTRL[4:3].
- R4: Flag bit 2+n is set in the cycle after `chan_evt[n]` is 1, for n = 0 to 5.
- R5: A flag is set when its trigger occurs, even if its enable bit is 0.
- R6: A flag stays set until a write to address 2 carries a 1 in its bit position. Zero bits in that write leave the other flags unchanged.
- R7: If a clear and a trigger for the same flag fall in the same cycle, the flag ends up set.
- R8: `irq` is a register. One cycle after the flags and enables change, it equals CTRL bit 1 AND CTRL bit 2 AND the OR over all bits of (flags AND enable mask). The enable mask is written at address 1 and uses the same bit layout as the flags.
- R9: `irq` stays 0 while either CTRL bit 1 or CTRL bit 2 is 0.
- R10: After reset, the counter, the flags, all enables, the run bit and `irq` are 0, and the width select is 8 bits.
- R11: A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter step pulse |
| chan_evt | input | 6 | Per-channel event triggers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = control, 1 = enable mask, 2 = clear flags, 3 = unused |
| wr_data | input | 8 | Write data |
| count | output | 16 | Counter value |
| flags | output | 8 | Pending flags: bit 0 = wrap, bit 1 = slice carry, bits 2 to 7 = channels |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench runs the counter across both overflow points for the narrowest and the widest slice setting. A wrong slice decode would set flag 1 early or late, for example at 255 when 11 bits are selected. It sets flags while their enables are 0. A design that masks at the latch would then show no pending flag, and no request once the enable is later set. It fires a channel event in the same cycle as its clear, and drives a clear with a partial mask. A design that gives the clear priority, or that clears whole registers, would lose flags. Each global gate is opened on its own, and a request that is missing a gate would go high too early.

// File: rtl/cia_pkg.sv
package cia_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_ENAB = 2'd1,
    A_CLR  = 2'd2,
    A_RSV  = 2'd3
  } cia_addr_e;

  // bit 0 run, bit 1 global gate, bit 2 block gate, bits 4:3 slice select
  typedef struct packed {
    logic [1:0] wsel;
    logic       blk_en;
    logic       gie;
    logic       run;
  } cia_ctrl_t;

  localparam int CTRL_W = 5;
endpackage

// File: rtl/cia_regs.sv
module cia_regs
  import cia_pkg::*;
#(
  parameter int NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NFLAG-1:0] wr_data,
  output cia_ctrl_t        ctrl,
  output logic [NFLAG-1:0] en_mask,
  output logic [NFLAG-1:0] clr_vec
);
  cia_addr_e addr;
  assign addr = cia_addr_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      en_mask <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl    <= cia_ctrl_t'(wr_data[CTRL_W-1:0]);
        A_ENAB:  en_mask <= wr_data;
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_en && addr == A_CLR) ? wr_data : '0;
endmodule

// File: rtl/cia_counter.sv
module cia_counter #(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 2,
  parameter int MID_BASE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SEL_W-1:0] wsel,
  output logic [CNT_W-1:0] count,
  output logic             full_trig,
  output logic             mid_trig
);
  logic [CNT_W-1:0] mid_mask;

  always_comb begin
    mid_mask = ~({CNT_W{1'b1}} << (MID_BASE + int'(wsel)));
  end

  assign full_trig = step && (count == {CNT_W{1'b1}});
  assign mid_trig  = step && ((count & mid_mask) == mid_mask);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/cia_flags.sv
module cia_flags #(
  parameter int NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] trig,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flags[i] <= 1'b0;
      else if (trig[i]) flags[i] <= 1'b1;
      else if (clr[i])  flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cntr_irq_agg.sv
module cntr_irq_agg
  import cia_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NCHAN    = 6,
  parameter int SEL_W    = 2,
  parameter int MID_BASE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cnt_en,
  input  logic [NCHAN-1:0]     chan_evt,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [NCHAN+1:0]     wr_data,
  output logic [CNT_W-1:0]     count,
  output logic [NCHAN+1:0]     flags,
  output logic                 irq
);
  localparam int NFLAG = NCHAN + 2;

  cia_ctrl_t        ctrl;
  logic [NFLAG-1:0] en_mask;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] trig;
  logic             full_trig, mid_trig;
  logic             run_w, gie_w, blk_w, step;

  assign run_w = ctrl.run;
  assign gie_w = ctrl.gie;
  assign blk_w = ctrl.blk_en;
  assign step  = run_w && cnt_en;

  cia_regs #(.NFLAG(NFLAG)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .en_mask(en_mask), .clr_vec(clr_vec)
  );

  cia_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MID_BASE(MID_BASE)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .wsel(ctrl.wsel),
    .count(count), .full_trig(full_trig), .mid_trig(mid_trig)
  );

  assign trig = {chan_evt, mid_trig, full_trig};

  cia_flags #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .trig(trig), .clr(clr_vec), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gie_w && blk_w && (|(flags & en_mask));
  end
endmodule

// File: rtl/cia_chk.sv
module cia_chk #(
  parameter int CNT_W = 16,
  parameter int NCHAN = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             run,
  input logic             gie,
  input logic             blk,
  input logic [NCHAN-1:0] chan_evt,
  input logic [NCHAN+1:0] clr_vec,
  input logic [NCHAN+1:0] flags,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_en) |=> count == CNT_W'($past(count) + 1'b1));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !(run && cnt_en) |=> $stable(count));

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_en && count == {CNT_W{1'b1}}) |=> flags[0]);

  assert_chan_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (|chan_evt) |=> ((flags[NCHAN+1:2] & $past(chan_evt)) == $past(chan_evt)));

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((($past(flags) & ~$past(clr_vec)) & ~flags) == '0));

  assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !(gie && blk) |=> !irq);
endmodule

bind cntr_irq_agg cia_chk #(.CNT_W(CNT_W), .NCHAN(NCHAN)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .run(run_w), .gie(gie_w),
  .blk(blk_w), .chan_evt(chan_evt), .clr_vec(clr_vec), .flags(flags),
  .count(count), .irq(irq)
);

// File: tb/cntr_irq_agg_tb.sv
module cntr_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [5:0]  chan_evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count;
  logic [7:0]  flags;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  int m_flags = 0;
  int m_en = 0;
  int m_ctrl = 0;
  bit m_irq = 0;

  always #4 clk = ~clk;

  cntr_irq_agg u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .chan_evt(chan_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .flags(flags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // model update on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_flags = 0; m_en = 0; m_ctrl = 0; m_irq = 0;
    end else begin
      int run, gie, blk, n, low, trig, clr;
      run = m_ctrl & 1;
      gie = (m_ctrl >> 1) & 1;
      blk = (m_ctrl >> 2) & 1;
      n   = 8 + ((m_ctrl >> 3) & 3);
      m_irq = (gie == 1) && (blk == 1) && ((m_flags & m_en) != 0);
      trig = int'(chan_evt) << 2;
      if (run == 1 && cnt_en) begin
        low = m_cnt % (1 << n);
        if (m_cnt == 65535) trig = trig | 1;
        if (low == (1 << n) - 1) trig = trig | 2;
        m_cnt = (m_cnt + 1) % 65536;
      end
      clr = (wr_en && wr_addr == 2) ? int'(wr_data) : 0;
      m_flags = ((m_flags & ~clr) | trig) & 255;
      if (wr_en && wr_addr == 0) m_ctrl = int'(wr_data) & 31;
      if (wr_en && wr_addr == 1) m_en = int'(wr_data);
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(count) == m_cnt, "R1 count", int'(count), m_cnt);
      chk(int'(flags) == m_flags, "R5 flags", int'(flags), m_flags);
      chk(irq == m_irq, "R8 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic tick(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(count == 16'd0, "R10 count", int'(count), 0);
    chk(flags == 8'd0, "R10 flags", int'(flags), 0);
    chk(irq == 1'b0, "R10 irq", int'(irq), 0);

    // R3 slice of 8 bits (reset default width)
    wr(2'd0, 8'h01);
    tick(255);
    chk(count == 16'd255, "R1 count after 255", int'(count), 255);
    chk(flags[1] == 1'b0, "R3 early", int'(flags[1]), 0);
    tick(1);
    chk(flags[1] == 1'b1, "R3 8-bit carry", int'(flags[1]), 1);
    chk(flags[0] == 1'b0, "R2 no wrap", int'(flags[0]), 0);
    // R5 latched although enable mask is zero
    chk(irq == 1'b0, "R5 masked irq", int'(irq), 0);

    // R9 gates opened one at a time
    wr(2'd1, 8'h02);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 both gates closed", int'(irq), 0);
    wr(2'd0, 8'h03);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 block gate closed", int'(irq), 0);
    wr(2'd0, 8'h05);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 global gate closed", int'(irq), 0);
    wr(2'd0, 8'h07);
    chk(irq == 1'b0, "R8 one cycle lag", int'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R8 request", int'(irq), 1);

    // R6 clear with a one
    wr(2'd2, 8'h02);
    chk(flags[1] == 1'b0, "R6 cleared", int'(flags[1]), 0);
    @(negedge clk);
    chk(irq == 1'b0, "R8 request drops", int'(irq), 0);

    // R4 channel events, then partial clear
    chan_evt = 6'b000101;
    @(negedge clk);
    chan_evt = '0;
    chk(flags[7:2] == 6'b000101, "R4 channel flags", int'(flags[7:2]), 5);
    wr(2'd2, 8'h04);
    chk(flags == 8'h10, "R6 partial clear", int'(flags), 16);

    // R7 trigger and clear together
    chan_evt = 6'b000001;
    wr(2'd2, 8'h04);
    chan_evt = '0;
    chk(flags[2] == 1'b1, "R7 trigger wins", int'(flags[2]), 1);

    // R11 reserved address ignored
    wr(2'd3, 8'hFF);
    repeat (2) @(negedge clk);
    chk(flags == 8'h14, "R11 flags kept", int'(flags), 20);
    chk(irq == 1'b0, "R11 enables kept", int'(irq), 0);

    // R3 slice of 11 bits
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h1F);
    tick(2047 - m_cnt);
    chk(count == 16'd2047, "R1 reach 2047", int'(count), 2047);
    chk(flags[1] == 1'b0, "R3 no early 11-bit", int'(flags[1]), 0);
    tick(1);
    chk(flags[1] == 1'b1, "R3 11-bit carry", int'(flags[1]), 1);

    // R1 run bit freezes the counter
    wr(2'd0, 8'h1E);
    tick(10);
    chk(count == 16'd2048, "R1 frozen", int'(count), 2048);

    // R2 full wrap
    wr(2'd0, 8'h1F);
    tick(65535 - m_cnt);
    chk(count == 16'hFFFF, "R1 at top", int'(count), 65535);
    chk(flags[0] == 1'b0, "R2 before wrap", int'(flags[0]), 0);
    tick(1);
    chk(count == 16'd0, "R1 wrapped", int'(count), 0);
    chk(flags[0] == 1'b1, "R2 wrap flag", int'(flags[0]), 1);
    wr(2'd1, 8'h01);
    @(negedge clk);
    chk(irq == 1'b1, "R8 wrap request", int'(irq), 1);

    @(negedge clk);
    finish_run();
  end
endmodule